// File: doc/BRIEF.md
# Complementary Dead-Time Clock Generator

This block turns one single-ended clock or PWM input into a pair of non-overlapping complementary drive signals for a half-bridge gate driver. The high-side output follows the input phase and the low-side output is its inverse. Around every transition both outputs are held low for a programmable number of system-clock cycles, so the two switches of the bridge can never conduct at the same time. The duty cycle comes entirely from the input waveform.

The input is asynchronous to the fast system clock and passes through a two-flop synchronizer. A settling counter derives a delayed copy of the synchronized level. That copy moves to the new level only after the input has held it for the programmed dead-time. Each output is the AND of the input and the delayed copy, taken with true polarity for the high side and inverted polarity for the low side. The dead-time request is sampled into an internal register while the block is in reset, and otherwise only in cycles where both outputs are low. There is no enable input.

Top module: `deadtime_clk_gen`

## Requirements
- R1: `hs_out` is high only when the synchronized input and its delayed (settled) copy are both high. Whenever `hs_out` is high, `pwm_in` was high at the rising clock edge three edges earlier.
- R2: `ls_out` is high only when the synchronized input and its delayed copy are both low. Whenever `ls_out` is high, `pwm_in` was low at the rising clock edge three edges earlier.
- R3: `hs_out` and `ls_out` are never high in the same cycle.
- R4: Take the rising clock edge that first samples a new `pwm_in` level as edge 1. The output that is on then turns off at edge 3, giving a fixed latency of two edges after capture.
- R5: After a rising input, `hs_out` rises exactly D edges after `ls_out` falls, where D is the active dead-time (0 to 255). Both outputs are low in between.
- R6: After a falling input, `ls_out` rises exactly D edges after `hs_out` falls, with both outputs low in between.
- R7: With D = 0 the two outputs swap on the same clock edge.
- R8: An input high pulse lasting W synchronized cycles with W <= D produces no `hs_out` pulse. With W > D it produces an `hs_out` pulse of W - D cycles. The same rule applies to input low gaps and `ls_out`.
- R9: `dt_value` is copied into the active dead-time during reset and on any edge where both outputs were low. A change of `dt_value` that is withdrawn while one output stays high has no effect on the following edges.
- R10: During reset both outputs are low, and the delayed copy is set to the synchronized input level. After reset releases, the first edge drives the output that matches the input level high, with no dead interval.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all timing is counted in its cycles |
| rst | input | 1 | Synchronous active-high reset |
| pwm_in | input | 1 | Asynchronous reference clock or PWM input |
| dt_value | input | DT_W (8) | Requested dead-time in system-clock cycles |
| hs_out | output | 1 | High-side drive, in phase with the input |
| ls_out | output | 1 | Low-side drive, inverse of the input |

## Verification
Every result is due at a fixed edge. The first output change occurs two edges after the capturing edge, and the second one D edges after that. This delay includes any dead-time register reload inside the dead band. The bench drives `pwm_in` and `dt_value` on falling clock edges. It counts falling edges from each stimulus, so a change due at capture edge k+n is expected at falling edge n+1. A behavioural model is stepped on each rising edge from the same inputs and compared with both outputs at every falling edge. Directed runs cover zero and maximum dead-time, pulses and gaps one cycle either side of D, and dead-time changes made inside and outside the dead band.

// File: rtl/dtg_pkg.sv
package dtg_pkg;
  localparam int DTG_DT_W        = 8;
  localparam int DTG_SYNC_STAGES = 2;

  typedef struct packed {
    logic hi;
    logic lo;
  } dtg_pair_t;
endpackage

// File: rtl/dtg_sync.sv
// Multi-stage level synchronizer for the asynchronous drive input.
module dtg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) chain <= din;
    end else begin : g_many
      always_ff @(posedge clk) chain <= {chain[STAGES-2:0], din};
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/dtg_settle.sv
// Delayed copy of the synchronized level: it adopts a new level only after
// the level has differed from it for dt_cur consecutive cycles.
module dtg_settle #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl,
  input  logic [DT_W-1:0] dt_cur,
  output logic            settled_nxt
);
  logic            settled;
  logic [DT_W-1:0] age, age_nxt;

  always_comb begin
    settled_nxt = settled;
    age_nxt     = '0;
    if (lvl != settled) begin
      if (age >= dt_cur) begin
        settled_nxt = lvl;
      end else begin
        age_nxt = age + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      settled <= lvl;
      age     <= '0;
    end else begin
      settled <= settled_nxt;
      age     <= age_nxt;
    end
  end
endmodule

// File: rtl/dtg_outreg.sv
// Registered complementary outputs and the active dead-time register.
module dtg_outreg #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            lvl,
  input  logic            settled_nxt,
  input  logic [DT_W-1:0] dt_req,
  output logic            hs,
  output logic            ls,
  output logic [DT_W-1:0] dt_cur
);
  import dtg_pkg::*;

  dtg_pair_t pair_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pair_q <= '0;
      dt_cur <= dt_req;
    end else begin
      pair_q.hi <= lvl & settled_nxt;
      pair_q.lo <= ~lvl & ~settled_nxt;
      if (!pair_q.hi && !pair_q.lo) dt_cur <= dt_req;
    end
  end

  assign hs = pair_q.hi;
  assign ls = pair_q.lo;
endmodule

// File: rtl/deadtime_clk_gen.sv
module deadtime_clk_gen #(
  parameter int DT_W        = dtg_pkg::DTG_DT_W,
  parameter int SYNC_STAGES = dtg_pkg::DTG_SYNC_STAGES
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pwm_in,
  input  logic [DT_W-1:0] dt_value,
  output logic            hs_out,
  output logic            ls_out
);
  logic            lvl_s;
  logic            settled_nxt;
  logic [DT_W-1:0] dt_cur;

  dtg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (pwm_in),
    .dout (lvl_s)
  );

  dtg_settle #(.DT_W(DT_W)) u_settle (
    .clk         (clk),
    .rst         (rst),
    .lvl         (lvl_s),
    .dt_cur      (dt_cur),
    .settled_nxt (settled_nxt)
  );

  dtg_outreg #(.DT_W(DT_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .lvl         (lvl_s),
    .settled_nxt (settled_nxt),
    .dt_req      (dt_value),
    .hs          (hs_out),
    .ls          (ls_out),
    .dt_cur      (dt_cur)
  );
endmodule

// File: rtl/deadtime_clk_gen_chk.sv
module deadtime_clk_gen_chk #(
  parameter int DT_W = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            pwm_in,
  input logic            hs_out,
  input logic            ls_out,
  input logic [DT_W-1:0] dt_cur
);
  logic [2:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 3'd7) since_rst <= since_rst + 3'd1;
  end

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (rst)
    !(hs_out && ls_out));

  assert_hs_phase_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && hs_out) |-> $past(pwm_in, 3));

  assert_ls_phase_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd3 && ls_out) |-> !$past(pwm_in, 3));

  assert_hs_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $rose(hs_out) && dt_cur != '0) |-> $past(!ls_out));

  assert_ls_gap_R6: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && $rose(ls_out) && dt_cur != '0) |-> $past(!hs_out));

  assert_dt_window_R9: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd1 && !$stable(dt_cur)) |-> $past(!hs_out && !ls_out));
endmodule

bind deadtime_clk_gen deadtime_clk_gen_chk #(.DT_W(DT_W)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .pwm_in (pwm_in),
  .hs_out (hs_out),
  .ls_out (ls_out),
  .dt_cur (dt_cur)
);

// File: tb/tb_deadtime_clk_gen.sv
`timescale 1ns/1ps
module tb_deadtime_clk_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pwm_in = 1'b0;
  logic [7:0] dt_value = 8'd4;
  logic       hs_out, ls_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  deadtime_clk_gen dut (
    .clk(clk), .rst(rst), .pwm_in(pwm_in), .dt_value(dt_value),
    .hs_out(hs_out), .ls_out(ls_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference: two-cycle pipeline, a level that follows the
  // input once it has persisted for the dead-time, and the load window.
  int pipe0 = 0, pipe1 = 0, held = 0, hold_age = 0, dt_now = 0;
  int exp_hs = 0, exp_ls = 0;

  always @(posedge clk) begin
    int cur;
    int was_idle;
    cur      = pipe1;
    was_idle = (exp_hs == 0 && exp_ls == 0);
    pipe1    = pipe0;
    pipe0    = int'(pwm_in);
    if (rst) begin
      held = cur; hold_age = 0; dt_now = int'(dt_value);
      exp_hs = 0; exp_ls = 0;
    end else begin
      if (cur == held) hold_age = 0;
      else if (hold_age >= dt_now) begin held = cur; hold_age = 0; end
      else hold_age++;
      exp_hs = (cur == 1 && held == 1) ? 1 : 0;
      exp_ls = (cur == 0 && held == 0) ? 1 : 0;
      if (was_idle) dt_now = int'(dt_value);
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(int'(hs_out) == exp_hs, "R1 hs vs model", int'(hs_out), exp_hs);
      chk(int'(ls_out) == exp_ls, "R2 ls vs model", int'(ls_out), exp_ls);
      chk(!(hs_out && ls_out), "R3 overlap", int'(hs_out && ls_out), 0);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset(input bit lvl, input int dt);
    rst = 1'b1; pwm_in = lvl; dt_value = dt[7:0];
    tick(4);
    rst = 1'b0;
  endtask

  // Drive a new level and count falling edges until each output change.
  task automatic measure(input bit val, output int t_off, output int t_on);
    t_off = -1; t_on = -1;
    pwm_in = val;
    for (int j = 1; j <= 400; j++) begin
      @(negedge clk);
      if (t_off < 0 && (val ? !ls_out : !hs_out)) t_off = j;
      if (t_on < 0 && (val ? hs_out : ls_out)) t_on = j;
      if (t_off >= 0 && t_on >= 0) break;
    end
  endtask

  task automatic pulse_count(input bit base, input int w, output int cnt);
    cnt = 0;
    pwm_in = ~base;
    for (int j = 0; j < w; j++) begin
      @(negedge clk);
      if (base ? ls_out : hs_out) cnt++;
    end
    pwm_in = base;
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (base ? ls_out : hs_out) cnt++;
    end
  endtask

  initial begin
    int a, b, c;
    // R10: reset state and first edge after release
    rst = 1'b1; pwm_in = 1'b0; dt_value = 8'd4;
    tick(3);
    chk(!hs_out && !ls_out, "R10 outputs low in reset", int'({hs_out, ls_out}), 0);
    tick(1);
    rst = 1'b0;
    tick(1);
    chk(ls_out && !hs_out, "R10 low input after reset", int'({hs_out, ls_out}), 1);

    // R4 R5 R6: dead-time 4
    measure(1'b1, a, b);
    chk(a == 3, "R4 ls off latency", a, 3);
    chk(b == 7, "R5 hs on after dead-time", b, 7);
    measure(1'b0, a, b);
    chk(a == 3, "R4 hs off latency", a, 3);
    chk(b == 7, "R6 ls on after dead-time", b, 7);

    // R10: high input through reset, hs right after release
    do_reset(1'b1, 4);
    tick(1);
    chk(hs_out && !ls_out, "R10 high input after reset", int'({hs_out, ls_out}), 2);

    // R7: zero dead-time
    do_reset(1'b0, 0);
    tick(5);
    measure(1'b1, a, b);
    chk(a == 3 && b == 3, "R7 same-edge swap rise", b, 3);
    measure(1'b0, a, b);
    chk(a == 3 && b == 3, "R7 same-edge swap fall", b, 3);

    // R5 R6: maximum dead-time
    do_reset(1'b0, 255);
    tick(5);
    measure(1'b1, a, b);
    chk(b == 258, "R5 dead-time 255", b, 258);
    measure(1'b0, a, b);
    chk(b == 258, "R6 dead-time 255", b, 258);

    // R8: pulses and gaps around D = 6
    do_reset(1'b0, 6);
    tick(10);
    pulse_count(1'b0, 6, c);
    chk(c == 0, "R8 high pulse W=D swallowed", c, 0);
    pulse_count(1'b0, 7, c);
    chk(c == 1, "R8 high pulse W=D+1", c, 1);
    pwm_in = 1'b1;
    tick(20);
    pulse_count(1'b1, 6, c);
    chk(c == 0, "R8 low gap W=D swallowed", c, 0);
    pulse_count(1'b1, 9, c);
    chk(c == 3, "R8 low gap W=D+3", c, 3);

    // R9: withdrawn change while hs high is ignored; change in dead band applies
    do_reset(1'b1, 4);
    tick(10);
    dt_value = 8'd20;
    tick(3);
    dt_value = 8'd4;
    tick(1);
    measure(1'b0, a, b);
    chk(b == 7, "R9 ignored outside dead band", b, 7);
    dt_value = 8'd10;
    tick(3);
    measure(1'b1, a, b);
    chk(b == 13, "R9 loaded in dead band", b, 13);

    // Mixed stream against the model (R1 R2 R3)
    for (int k = 0; k < 300; k++) begin
      pwm_in = ~pwm_in;
      if ($urandom_range(0, 7) == 0) dt_value = 8'($urandom_range(0, 12));
      tick($urandom_range(1, 24));
    end
    tick(40);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL R4 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule